// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a free-running seconds counter meant for an always-powered domain. A single-cycle slow-clock enable (nominally 32768 pulses per second) feeds a 16-bit prescaler. Each time the prescaler completes one full division, the 32-bit counter steps by one. Software cannot load the counter. It can only restart both the prescaler and the counter from zero through a self-clearing bit in the mode register.

An alarm comparator raises a sticky flag on the tick that makes the counter equal to the alarm register. The all-ones alarm value stands for "no alarm". A second sticky flag records every counter increment. Both flags clear when the status register is read. The single interrupt output combines each flag with its own enable bit; each enable sits 16 bit positions above its flag. A 32-bit backup register gives software a word of storage that the timer restart does not touch.

All registers sit in the `clk` domain, so a read returns a value that is steady within its cycle. The bus is a simple single-cycle select/write port with combinational read data.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the register values are as follows, and `irq` is low:

| Offset | Register | Reset value |
|---|---|---|
| 0x00 | mode | 0x0000_8000 |
| 0x04 | alarm | 0xFFFF_FFFF |
| 0x08 | counter | 0 |
| 0x0C | status | 0 |
| 0x10 | backup | 0 |

- R2: The mode register fields are:
  - bits [15:0]: divide value P.
  - bit 16: alarm interrupt enable.
  - bit 17: increment interrupt enable.
  - bit 18: timer restart, which reads back as 0.

  With P nonzero, the counter (offset 0x08) steps by exactly one for every P slow-clock enable pulses.
- R3: A divide value of 0 divides by 65536.
- R4: Writing the mode register with bit 18 set clears the counter and the prescaler in that write cycle. The backup register and the alarm register keep their values.
- R5: Writes to the counter offset 0x08 have no effect.
- R6: Status bit 0 (alarm flag) sets on the tick at which the counter becomes equal to the alarm register (offset 0x04). It never sets while the alarm register holds 0xFFFF_FFFF. Ticks at other counter values do not set it.
- R7: Status bit 1 (increment flag) sets on every counter tick.
- R8: Reading the status register (offset 0x0C) clears both flags. A flag event in the same cycle as the read wins, so the flag stays set.
- R9: `irq` is high exactly when (status bit 0 AND mode bit 16) OR (status bit 1 AND mode bit 17). Clearing an enable drops `irq` without clearing the flag.
- R10: The backup register (offset 0x10) reads back the last value written to it.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One pulse per slow-clock period |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach is a status read that falls in the same cycle as a counter tick. In that cycle the clear and the set compete, and losing the event would be silent. The stimulus sets the divide value to 1 and holds the slow enable high, so every cycle is a tick. It then issues the status read and, in the following cycles, checks that the increment flag survived and that only a read with no tick clears it. The alarm edge is reached the same way: after a restart, the bench counts slow pulses exactly, so the counter lands one short of the alarm and then on it.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned PRESC_W = 16;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned NFLAG   = 2;
  localparam int unsigned IE_OFS  = 16;

  localparam logic [4:0] A_MODE   = 5'h00;
  localparam logic [4:0] A_ALARM  = 5'h04;
  localparam logic [4:0] A_COUNT  = 5'h08;
  localparam logic [4:0] A_STAT   = 5'h0C;
  localparam logic [4:0] A_BACKUP = 5'h10;

  localparam int unsigned F_ALM  = 0;
  localparam int unsigned F_INC  = 1;
  localparam int unsigned B_TRST = 18;

  localparam logic [PRESC_W-1:0] DIV_RESET = 16'h8000;

  // last prescaler state before wrap; zero divide means full range
  function automatic logic [PRESC_W-1:0] last_phase(input logic [PRESC_W-1:0] dv);
    if (dv == '0) return '1;
    return dv - 1'b1;
  endfunction

  // alarm comparison with the all-ones value meaning disarmed
  function automatic logic alarm_due(input logic [CNT_W-1:0] nxt,
                                     input logic [CNT_W-1:0] alm);
    return (alm != '1) && (nxt == alm);
  endfunction
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler import sat_pkg::*; #(
  parameter int unsigned PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          slow_en,
  input  logic [PW-1:0] div,
  output logic          tick,
  output logic [PW-1:0] phase
);
  logic [PW-1:0] last;
  logic          at_end;

  always_comb begin
    last   = last_phase(div);
    at_end = (phase >= last);
    tick   = slow_en && !clr && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr)     phase <= '0;
    else if (slow_en) phase <= at_end ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter import sat_pkg::*; #(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] alarm_val,
  output logic [CW-1:0] count,
  output logic          alarm_hit
);
  logic [CW-1:0] nxt;

  always_comb begin
    nxt       = count + 1'b1;
    alarm_hit = tick && !clr && alarm_due(nxt, alarm_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= nxt;
  end
endmodule

// File: rtl/sat_status.sv
module sat_status import sat_pkg::*; #(
  parameter int unsigned NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic          rd_clr,
  input  logic [NF-1:0] enable,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] live;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (set_ev[i]) flags[i] <= 1'b1;
      else if (rd_clr)    flags[i] <= 1'b0;
    end
    assign live[i] = flags[i] & enable[i];
  end

  assign irq = |live;
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer import sat_pkg::*; #(
  parameter int unsigned PW = PRESC_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [4:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int unsigned NF = NFLAG;

  logic [PW-1:0] div_q;
  logic [NF-1:0] ie_q;
  logic [CW-1:0] alarm_q;
  logic [31:0]   backup_q;

  logic wr_cyc, rd_cyc, tmr_rst, stat_rd;
  logic sec_tick, alarm_hit;
  logic [PW-1:0] pcnt_q;
  logic [CW-1:0] cnt_q;
  logic [NF-1:0] stat_q, set_ev;

  assign wr_cyc  = bus_sel && bus_wr;
  assign rd_cyc  = bus_sel && !bus_wr;
  assign tmr_rst = wr_cyc && (bus_addr == A_MODE) && bus_wdata[B_TRST];
  assign stat_rd = rd_cyc && (bus_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_RESET;
      ie_q     <= '0;
      alarm_q  <= '1;
      backup_q <= '0;
    end else if (wr_cyc) begin
      case (bus_addr)
        A_MODE: begin
          div_q <= bus_wdata[PW-1:0];
          ie_q  <= bus_wdata[IE_OFS +: NF];
        end
        A_ALARM:  alarm_q  <= bus_wdata[CW-1:0];
        A_BACKUP: backup_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  sat_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(tmr_rst), .slow_en(slow_en),
    .div(div_q), .tick(sec_tick), .phase(pcnt_q)
  );

  sat_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(tmr_rst), .tick(sec_tick),
    .alarm_val(alarm_q), .count(cnt_q), .alarm_hit(alarm_hit)
  );

  always_comb begin
    set_ev        = '0;
    set_ev[F_ALM] = alarm_hit;
    set_ev[F_INC] = sec_tick;
  end

  sat_status #(.NF(NF)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .rd_clr(stat_rd),
    .enable(ie_q), .flags(stat_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (bus_addr)
        A_MODE: begin
          bus_rdata[PW-1:0]         = div_q;
          bus_rdata[IE_OFS +: NF]   = ie_q;
        end
        A_ALARM:  bus_rdata[CW-1:0] = alarm_q;
        A_COUNT:  bus_rdata[CW-1:0] = cnt_q;
        A_STAT:   bus_rdata[NF-1:0] = stat_q;
        A_BACKUP: bus_rdata         = backup_q;
        default:  bus_rdata         = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk import sat_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          tmr_rst,
  input logic          stat_rd,
  input logic          alarm_hit,
  input logic [15:0]   pcnt_q,
  input logic [31:0]   cnt_q,
  input logic [31:0]   alarm_q,
  input logic [1:0]    stat_q,
  input logic [1:0]    ie_q,
  input logic          irq
);
  // R2: counter holds between ticks
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick && !tmr_rst |=> $stable(cnt_q));
  // R2: counter steps by one on a tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !tmr_rst |=> cnt_q == $past(cnt_q) + 32'd1);
  // R4: restart clears counter and prescaler
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |=> (cnt_q == 32'd0) && (pcnt_q == 16'd0));
  // R6: disarmed alarm never fires
  a_r6_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q == 32'hFFFF_FFFF) |-> !alarm_hit);
  // R6: alarm flag set only after a tick onto the alarm value
  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> stat_q[0] && (cnt_q == $past(alarm_q)));
  // R7: every tick leaves the increment flag set
  a_r7_inc: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> stat_q[1]);
  // R8: a status read with no event clears both flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !sec_tick |=> stat_q == 2'b00);
  // R9: no interrupt without an enable
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == 2'b00) |-> !irq);
endmodule

bind sec_alarm_timer sec_alarm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tmr_rst(tmr_rst),
  .stat_rd(stat_rd), .alarm_hit(alarm_hit), .pcnt_q(pcnt_q),
  .cnt_q(cnt_q), .alarm_q(alarm_q), .stat_q(stat_q), .ie_q(ie_q), .irq(irq)
);

// File: tb/tb_sec_alarm_timer.sv
module tb_sec_alarm_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_en = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sec_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [31:0] TRST   = 32'h0004_0000;
  localparam logic [31:0] IE_ALM = 32'h0001_0000;
  localparam logic [31:0] IE_INC = 32'h0002_0000;

  function automatic logic [31:0] exp_count(input int unsigned pulses, input int unsigned dv);
    int unsigned d = (dv == 0) ? 65536 : dv;
    return pulses / d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic run(input int unsigned k);
    if (k != 0) begin
      slow_en = 1'b1;
      repeat (k) @(negedge clk);
      slow_en = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, v); chk("R1 mode", v, 32'h0000_8000);
    rd(5'h04, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R1 count", v, 32'h0);
    rd(5'h0C, v); chk("R1 status", v, 32'h0);
    rd(5'h10, v); chk("R1 backup", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R10 backup
    wr(5'h10, 32'hA5A5_1234);
    rd(5'h10, v); chk("R10 backup", v, 32'hA5A5_1234);

    // R4 restart clears counter and prescaler
    wr(5'h00, TRST | 32'd3);
    run(7);
    rd(5'h08, v); chk("R2 count div3", v, 32'd2);
    rd(5'h00, v); chk("R4 restart bit reads 0", v, 32'd3);
    wr(5'h00, TRST | 32'd3);
    rd(5'h08, v); chk("R4 count cleared", v, 32'd0);
    run(2);
    rd(5'h08, v); chk("R4 prescaler cleared", v, 32'd0);
    run(1);
    rd(5'h08, v); chk("R4 first tick", v, 32'd1);
    rd(5'h10, v); chk("R4 backup kept", v, 32'hA5A5_1234);

    // R5 counter not writable
    wr(5'h08, 32'h0000_1234);
    rd(5'h08, v); chk("R5 count write ignored", v, 32'd1);

    // R11 unmapped
    rd(5'h14, v); chk("R11 unmapped 0x14", v, 32'h0);
    rd(5'h1C, v); chk("R11 unmapped 0x1C", v, 32'h0);

    // R7 / R8
    rd(5'h0C, v);
    run(3);
    rd(5'h0C, v); chk("R7 inc flag", v, 32'd2);
    rd(5'h0C, v); chk("R8 cleared by read", v, 32'd0);

    // R6 alarm match
    wr(5'h00, TRST | 32'd2);
    wr(5'h04, 32'd5);
    rd(5'h04, v); chk("R4 alarm kept", v, 32'd5);
    rd(5'h0C, v);
    run(9);
    rd(5'h08, v); chk("R6 count before alarm", v, 32'd4);
    rd(5'h0C, v); chk("R6 no early alarm", v, 32'd2);
    run(1);
    rd(5'h08, v); chk("R6 count at alarm", v, 32'd5);
    rd(5'h0C, v); chk("R6 alarm flag", v, 32'd3);
    run(20);
    rd(5'h0C, v); chk("R6 no alarm after pass", v, 32'd2);

    // R6 sentinel
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h00, TRST | 32'd1);
    run(10);
    rd(5'h0C, v); chk("R6 disarmed", v, 32'd2);

    // R9 increment enable
    wr(5'h00, IE_INC | 32'd1);
    chk("R9 irq low no flag", {31'b0, irq}, 32'h0);
    run(1);
    chk("R9 irq inc", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'd1);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(5'h0C, v); chk("R9 flag kept", v, 32'd2);

    // R9 alarm enable
    wr(5'h04, 32'd3);
    wr(5'h00, TRST | IE_ALM | 32'd1);
    run(2);
    chk("R9 inc not enabled", {31'b0, irq}, 32'h0);
    run(1);
    chk("R9 irq alarm", {31'b0, irq}, 32'h1);
    rd(5'h0C, v); chk("R9 alarm status", v, 32'd3);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);

    // R8 set wins over clear
    rd(5'h0C, v);
    slow_en = 1'b1;
    rd(5'h0C, v); chk("R8 read while ticking", v, 32'd0);
    slow_en = 1'b0;
    rd(5'h0C, v); chk("R8 set wins", v, 32'd2);
    rd(5'h0C, v); chk("R8 later clear", v, 32'd0);

    // R3 divide by 65536
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h00, TRST);
    run(65535);
    rd(5'h08, v); chk("R3 before wrap", v, 32'd0);
    run(1);
    rd(5'h08, v); chk("R3 after wrap", v, 32'd1);

    // R2 random divide values and pulse counts, R10 random backup
    for (int i = 0; i < 20; i++) begin
      int unsigned dv = $urandom_range(1, 9);
      int unsigned k  = $urandom_range(0, 60);
      logic [31:0] bk = $urandom;
      wr(5'h00, TRST | dv);
      run(k);
      rd(5'h08, v); chk("R2 random count", v, exp_count(k, dv));
      wr(5'h10, bk);
      rd(5'h10, v); chk("R10 random backup", v, bk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule